// File: doc/BRIEF.md
# Shift-and-Add Constant-Coefficient FIR Filter

This block is a fixed-point FIR filter with eight taps by default. It takes a stream of unsigned samples together with a valid strobe. It produces one full-precision sum for every accepted sample. No tap uses a general multiplier. Each coefficient is given as a short list of power-of-two terms. A tap's product is the sample shifted to each listed position, and those shifted copies are combined with one or two adders. Coefficient bits that are zero cost no logic.

Each tap has its own descriptor, which selects one of two forms:
- **Signed-digit form:** up to two terms, each added or subtracted, so the tap needs one adder/subtractor.
- **Positive form:** up to three distinct set bits, so the tap needs two adders.

A descriptor that breaks the rules of its form is not used: that tap contributes zero, and a sticky flag reports the fault. Products flow through a registered binary adder tree. The output therefore has a fixed latency, and the valid strobe travels alongside the data.

Top module: `spt_fir`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0, `out_sum` is 0 and `desc_err` is 0. Reset also clears the sample history to zeros.
- R2: Each sample accepted with `in_valid` high at a clock edge produces exactly one `out_valid` pulse, 5 clock edges later (latency is log2(NTAPS)+2). `out_valid` is low in every other cycle.
- R3: Each result equals the sum over taps j of coef[j] times x[n-j]. Tap 0 holds the newest accepted sample, and history from before reset counts as zero.
- R4: The sample history advances only on cycles with `in_valid` high. Idle gaps between samples do not change any later result.
- R5: Descriptor encoding: tap j uses `tap_desc[16j+15:16j]`. Bit 15 selects signed-digit form (1) or positive form (0). Term k occupies bits [5k+4:5k]; within a term, bit 4 is enable, bit 3 is negate, and bits 2:0 are the shift position. In signed-digit form, the coefficient is the sum of ±2^pos over the enabled terms 0 and 1. This reproduces 7=8-1, 9=8+1, 24=16+8 and 56=64-8 exactly.
- R6: In positive form, the coefficient is the sum of 2^pos over up to three enabled terms (0, 1, 2), giving values from 0 to 224.
- R7: Some descriptors are illegal:
  - signed-digit form with term 2 enabled;
  - any form with two enabled terms at the same position;
  - positive form with an enabled term negated.

  An illegal descriptor makes its tap contribute zero. It also sets `desc_err` on the next clock edge, and `desc_err` stays high until reset, even after the descriptor is corrected.
- R8: Results are never wrapped. The extreme sums +456960 (every tap 224, every sample 255) and -391680 (every tap -192, every sample 255) appear exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Unsigned input sample |
| tap_desc | input | 16*NTAPS | Per-tap coefficient descriptors |
| out_valid | output | 1 | Result strobe |
| out_sum | output | SW | Signed full-precision sum (20 bits by default) |
| desc_err | output | 1 | Sticky illegal-descriptor flag |

## Verification
The bench builds the filter with its defaults: 8-bit samples and eight taps. With these values the adder tree is a full three-level tree with 5-cycle latency, so the pipeline fills and drains in a handful of cycles. They also put both extreme sums within reach after only eight identical samples. Because the form is chosen per tap, signed-digit and positive taps can be mixed inside one instance. That lets random descriptor sets, the four example coefficients, and each kind of illegal descriptor all be driven through a single build.

// File: rtl/spt_pkg.sv
`timescale 1ns/1ps
package spt_pkg;
  localparam int POS_W  = 3;
  localparam int TERMS  = 3;
  localparam int TERM_W = POS_W + 2;
  localparam int DESC_W = TERMS * TERM_W + 1;

  typedef struct packed {
    logic             en;
    logic             neg;
    logic [POS_W-1:0] pos;
  } term_t;

  typedef struct packed {
    logic                    sd_mode;
    term_t [TERMS-1:0]       t;
  } desc_t;

  // Legal when no two enabled terms share a position, and the form's
  // own limit holds: signed-digit uses at most terms 0 and 1, positive
  // form never negates.
  function automatic logic desc_legal(desc_t d);
    logic ok;
    ok = 1'b1;
    for (int a = 0; a < TERMS; a++) begin
      for (int b = a + 1; b < TERMS; b++) begin
        if (d.t[a].en && d.t[b].en && (d.t[a].pos == d.t[b].pos)) ok = 1'b0;
      end
    end
    if (d.sd_mode) begin
      if (d.t[TERMS-1].en) ok = 1'b0;
    end else begin
      for (int a = 0; a < TERMS; a++) begin
        if (d.t[a].en && d.t[a].neg) ok = 1'b0;
      end
    end
    return ok;
  endfunction
endpackage

// File: rtl/spt_tap_line.sv
`timescale 1ns/1ps
module spt_tap_line #(
  parameter int DW    = 8,
  parameter int NTAPS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic [DW-1:0]         din,
  output logic [NTAPS*DW-1:0]   taps
);
  logic [DW-1:0] sr [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) sr[i] <= '0;
    end else if (shift_en) begin
      sr[0] <= din;
      for (int i = 1; i < NTAPS; i++) sr[i] <= sr[i-1];
    end
  end

  generate
    for (genvar i = 0; i < NTAPS; i++) begin : g_out
      assign taps[i*DW +: DW] = sr[i];
    end
  endgenerate
endmodule

// File: rtl/spt_tap_mult.sv
`timescale 1ns/1ps
module spt_tap_mult
  import spt_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = DW + (1 << POS_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        sample,
  input  desc_t                desc,
  output logic signed [PW-1:0] prod,
  output logic                 bad
);
  logic signed [PW-1:0] mag [TERMS];
  logic signed [PW-1:0] sd_first;
  logic signed [PW-1:0] sd_val;
  logic signed [PW-1:0] us_val;

  // Only enabled positions contribute a shifted copy of the sample.
  generate
    for (genvar k = 0; k < TERMS; k++) begin : g_term
      assign mag[k] = desc.t[k].en ? (PW'(sample) << desc.t[k].pos) : '0;
    end
  endgenerate

  always_comb begin
    bad      = !desc_legal(desc);
    sd_first = desc.t[0].neg ? -mag[0] : mag[0];
    sd_val   = desc.t[1].neg ? (sd_first - mag[1]) : (sd_first + mag[1]);
    us_val   = mag[0] + mag[1] + mag[2];
  end

  always_ff @(posedge clk) begin
    if (rst)          prod <= '0;
    else if (bad)     prod <= '0;
    else if (desc.sd_mode) prod <= sd_val;
    else              prod <= us_val;
  end
endmodule

// File: rtl/spt_sum_tree.sv
`timescale 1ns/1ps
module spt_sum_tree #(
  parameter int IW    = 17,
  parameter int NLEAF = 8,
  parameter int OW    = IW + $clog2(NLEAF)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NLEAF*IW-1:0]   leaves,
  output logic signed [OW-1:0]  sum
);
  localparam int LEVELS = $clog2(NLEAF);
  localparam int NP     = 1 << LEVELS;
  localparam int NINT   = NP - 1;

  logic signed [OW-1:0] leaf [NP];
  logic signed [OW-1:0] acc  [NINT];
  logic signed [OW-1:0] all  [2*NP-1];

  // Heap layout: node i has children 2i+1 and 2i+2; leaves follow the
  // internal nodes. Missing leaves are padded with zero.
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (i < NLEAF) leaf[i] = OW'($signed(leaves[i*IW +: IW]));
      else           leaf[i] = '0;
    end
    for (int i = 0; i < NINT; i++) all[i] = acc[i];
    for (int i = 0; i < NP; i++)   all[NINT+i] = leaf[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NINT; i++) acc[i] <= '0;
    end else begin
      for (int i = 0; i < NINT; i++) acc[i] <= all[2*i+1] + all[2*i+2];
    end
  end

  assign sum = acc[0];
endmodule

// File: rtl/spt_fir.sv
`timescale 1ns/1ps
module spt_fir
  import spt_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NTAPS = 8,
  parameter int SW    = DW + (1 << POS_W) + 1 + $clog2(NTAPS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_sample,
  input  logic [NTAPS*DESC_W-1:0]   tap_desc,
  output logic                      out_valid,
  output logic signed [SW-1:0]      out_sum,
  output logic                      desc_err
);
  localparam int PW     = DW + (1 << POS_W) + 1;
  localparam int LEVELS = $clog2(NTAPS);
  localparam int LAT    = LEVELS + 2;

  logic [NTAPS*DW-1:0] taps;
  logic [NTAPS*PW-1:0] prods;
  logic [NTAPS-1:0]    bad;
  logic [LAT-1:0]      vpipe;

  spt_tap_line #(.DW(DW), .NTAPS(NTAPS)) line_i (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_sample), .taps(taps)
  );

  generate
    for (genvar j = 0; j < NTAPS; j++) begin : g_tap
      logic signed [PW-1:0] p;
      spt_tap_mult #(.DW(DW), .PW(PW)) mult_i (
        .clk(clk), .rst(rst),
        .sample(taps[j*DW +: DW]),
        .desc(desc_t'(tap_desc[j*DESC_W +: DESC_W])),
        .prod(p), .bad(bad[j])
      );
      assign prods[j*PW +: PW] = p;
    end
  endgenerate

  spt_sum_tree #(.IW(PW), .NLEAF(NTAPS), .OW(SW)) tree_i (
    .clk(clk), .rst(rst), .leaves(prods), .sum(out_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe    <= '0;
      desc_err <= 1'b0;
    end else begin
      vpipe    <= {vpipe[LAT-2:0], in_valid};
      desc_err <= desc_err | (|bad);
    end
  end

  assign out_valid = vpipe[LAT-1];
endmodule

// File: rtl/spt_fir_chk.sv
`timescale 1ns/1ps
module spt_fir_chk #(
  parameter int DW    = 8,
  parameter int NTAPS = 8,
  parameter int SW    = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_sum,
  input logic                 desc_err
);
  localparam int    LAT   = $clog2(NTAPS) + 2;
  localparam int    MAXSH = (1 << spt_pkg::POS_W) - 1;
  localparam longint SMAX = longint'(NTAPS) * ((longint'(1) << DW) - 1) * (longint'(7) << (MAXSH - 2));
  localparam longint SMIN = -longint'(NTAPS) * ((longint'(1) << DW) - 1) * (longint'(3) << (MAXSH - 1));

  logic [LAT-1:0] vhist;
  always_ff @(posedge clk) begin
    if (rst) vhist <= '0;
    else     vhist <= {vhist[LAT-2:0], in_valid};
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sum == '0 && !desc_err));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vhist[LAT-1]);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    desc_err |=> desc_err);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_sum) <= SMAX && longint'(out_sum) >= SMIN));
endmodule

bind spt_fir spt_fir_chk #(.DW(DW), .NTAPS(NTAPS), .SW(SW)) chk_i (.*);

// File: tb/spt_fir_tb_top.sv
`timescale 1ns/1ps
module spt_fir_tb_top;
  localparam int DW    = 8;
  localparam int NTAPS = 8;
  localparam int DSW   = 16;
  localparam int LAT   = $clog2(NTAPS) + 2;
  localparam int SW    = DW + 9 + $clog2(NTAPS);

  typedef struct { int cyc; longint val; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_sample = '0;
  logic [NTAPS*DSW-1:0] tap_desc = '0;
  logic out_valid;
  logic signed [SW-1:0] out_sum;
  logic desc_err;

  int checks = 0, errors = 0, cyc = 0;
  int coef [NTAPS];
  int hist [NTAPS];
  exp_t q [$];
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spt_fir #(.DW(DW), .NTAPS(NTAPS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .tap_desc(tap_desc), .out_valid(out_valid), .out_sum(out_sum), .desc_err(desc_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [4:0] term(input bit en, input bit neg, input int pos);
    return {en, neg, 3'(pos)};
  endfunction

  function automatic int pw(input bit neg, input int pos);
    return neg ? -(1 << pos) : (1 << pos);
  endfunction

  // signed-digit form, terms 0 and 1 (R5)
  task automatic set_sd(input int j, input bit e0, input bit n0, input int p0,
                        input bit e1, input bit n1, input int p1);
    tap_desc[j*DSW +: DSW] = {1'b1, 5'b0, term(e1, n1, p1), term(e0, n0, p0)};
    coef[j] = (e0 ? pw(n0, p0) : 0) + (e1 ? pw(n1, p1) : 0);
  endtask

  // positive form, up to three terms (R6)
  task automatic set_us(input int j, input bit e0, input int p0, input bit e1,
                        input int p1, input bit e2, input int p2);
    tap_desc[j*DSW +: DSW] = {1'b0, term(e2, 0, p2), term(e1, 0, p1), term(e0, 0, p0)};
    coef[j] = (e0 ? (1 << p0) : 0) + (e1 ? (1 << p1) : 0) + (e2 ? (1 << p2) : 0);
  endtask

  task automatic rand_tap(input int j);
    int p0, p1, p2;
    p0 = $urandom_range(0, 7);
    p1 = (p0 + 1 + $urandom_range(0, 6)) % 8;
    do p2 = $urandom_range(0, 7); while (p2 == p0 || p2 == p1);
    if ($urandom_range(0, 1) == 1)
      set_sd(j, 1'($urandom_range(0,1)), 1'($urandom_range(0,1)), p0,
                1'($urandom_range(0,1)), 1'($urandom_range(0,1)), p1);
    else
      set_us(j, 1'($urandom_range(0,1)), p0, 1'($urandom_range(0,1)), p1,
                1'($urandom_range(0,1)), p2);
  endtask

  task automatic send(input int x, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = DW'(x);
    for (int j = NTAPS - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    e.val = 0;
    for (int j = 0; j < NTAPS; j++) e.val += longint'(coef[j]) * hist[j];
    e.cyc = cyc + LAT;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  task automatic do_reset();
    drain();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(out_sum == '0, "R1", "out_sum in reset", out_sum, 0);
    chk(desc_err == 1'b0, "R1", "desc_err in reset", desc_err, 0);
    rst = 1'b0;
    for (int j = 0; j < NTAPS; j++) hist[j] = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (!rst && !done) begin
      if (q.size() != 0 && q[0].cyc == cyc) begin
        e = q.pop_front();
        chk(out_valid == 1'b1, "R2", "out_valid at expected cycle", out_valid, 1);
        chk(longint'(out_sum) == e.val, e.tag, "out_sum", longint'(out_sum), e.val);
      end else if (out_valid) begin
        chk(1'b0, "R2", "unexpected out_valid", 1, 0);
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int j = 0; j < NTAPS; j++) begin coef[j] = 0; hist[j] = 0; end
    for (int j = 0; j < NTAPS; j++) set_sd(j, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    do_reset();  // R1

    // R5: the example coefficients, by impulse response
    set_sd(0, 1, 0, 3, 1, 1, 0);   // 7
    set_sd(1, 1, 0, 3, 1, 0, 0);   // 9
    set_sd(2, 1, 0, 4, 1, 0, 3);   // 24
    set_sd(3, 1, 0, 6, 1, 1, 3);   // 56
    set_sd(4, 1, 1, 6, 1, 0, 3);   // -56
    set_sd(5, 1, 0, 0, 0, 0, 0);   // 1
    set_sd(6, 1, 1, 7, 0, 0, 0);   // -128
    set_sd(7, 0, 0, 0, 0, 0, 0);   // 0
    send(1, "R5");
    for (int i = 0; i < NTAPS; i++) send(0, "R5");
    send(255, "R5");
    for (int i = 0; i < NTAPS; i++) send(0, "R5");
    drain();

    // R3 / R6: random mixed descriptors, back-to-back samples
    for (int blk = 0; blk < 6; blk++) begin
      for (int j = 0; j < NTAPS; j++) rand_tap(j);
      for (int i = 0; i < 40; i++) send($urandom_range(0, 255), "R3");
      drain();
    end
    for (int j = 0; j < NTAPS; j++)
      set_us(j, 1, $urandom_range(0,2), 1, $urandom_range(3,5), 1, $urandom_range(6,7));
    for (int i = 0; i < 40; i++) send($urandom_range(0, 255), "R6");
    drain();

    // R4: random gaps between samples
    for (int j = 0; j < NTAPS; j++) rand_tap(j);
    for (int i = 0; i < 80; i++) begin
      send($urandom_range(0, 255), "R4");
      idle($urandom_range(0, 3));
    end
    drain();

    // R8: extremes
    for (int j = 0; j < NTAPS; j++) set_us(j, 1, 7, 1, 6, 1, 5);
    for (int i = 0; i < 10; i++) send(255, "R8");
    drain();
    for (int j = 0; j < NTAPS; j++) set_sd(j, 1, 1, 7, 1, 1, 6);
    for (int i = 0; i < 10; i++) send(255, "R8");
    drain();

    // R7: signed-digit with term 2 enabled
    for (int j = 0; j < NTAPS; j++) rand_tap(j);
    do_reset();
    idle(2);
    chk(desc_err == 1'b0, "R7", "desc_err with legal set", desc_err, 0);
    tap_desc[2*DSW +: DSW] = {1'b1, term(1, 0, 4), 5'b0, term(1, 0, 2)};
    coef[2] = 0;
    idle(2);
    chk(desc_err == 1'b1, "R7", "desc_err after term-2 in signed form", desc_err, 1);
    for (int i = 0; i < 30; i++) send($urandom_range(0, 255), "R7");
    drain();
    set_sd(2, 1, 0, 3, 0, 0, 0);
    idle(4);
    chk(desc_err == 1'b1, "R7", "desc_err held after fix", desc_err, 1);

    // R7: negated term in positive form
    do_reset();
    tap_desc[5*DSW +: DSW] = {1'b0, 5'b0, term(1, 0, 5), term(1, 1, 1)};
    coef[5] = 0;
    idle(2);
    chk(desc_err == 1'b1, "R7", "desc_err after negated positive term", desc_err, 1);
    for (int i = 0; i < 30; i++) send($urandom_range(0, 255), "R7");
    drain();

    // R7: duplicate positions
    set_us(5, 1, 1, 0, 0, 0, 0);
    do_reset();
    tap_desc[0*DSW +: DSW] = {1'b0, term(1, 0, 6), 5'b0, term(1, 0, 6)};
    coef[0] = 0;
    idle(2);
    chk(desc_err == 1'b1, "R7", "desc_err after duplicate position", desc_err, 1);
    for (int i = 0; i < 30; i++) send($urandom_range(0, 255), "R7");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule